// File: doc/BRIEF.md
# Serial Debug Monitor Command Engine

This block is the target-side half of a text-based debug monitor. A host sends ASCII command lines one byte at a time over a receive stream. The engine parses each line, reads the requested state through a synchronous memory read port or a register-file read port, and streams the answer back as hexadecimal text on a transmit stream. Both streams use valid/ready handshakes. Bit-level serial framing is handled elsewhere.

Two commands exist. The memory command is `m`, then a hexadecimal start address, a comma and a hexadecimal count. It returns that many consecutive memory locations. The register command is `g` on its own. It returns every core register in index order. Any malformed line gets a short error reply. While a reply is being formed, the receive stream is held off, so no host byte is lost.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, `rx_ready` is 1 and `tx_valid`, `mem_rd` and `reg_rd` are 0.
- R2: A line `m<addr>,<len>` returns `len` locations starting at `addr`. Both fields are hexadecimal, and the digits 0-9, A-F and a-f are accepted. Each location is sent as DATA_W/4 uppercase hex characters, most significant nibble first, with no separators. The reply ends with one line feed (0x0A).
- R3: A carriage return (0x0D) or a line feed (0x0A) ends a command. A terminator that arrives with no command pending produces no reply.
- R4: Spaces (0x20) are ignored in three places: between `m` and the first address digit, after `g`, and before a command letter.
- R5: A line `g` returns NUM_REGS registers in index order starting at index 0. Each register is sent as REG_W/4 uppercase hex characters, most significant nibble first, followed by one line feed.
- R6: Any of the following discards the rest of the line up to its terminator and then replies `E` (0x45) followed by a line feed: an unknown command letter (uppercase `M` and `G` are unknown), a non-hex character inside a field, a missing comma, or an empty address or length field.
- R7: A memory command with length 0 replies with a single line feed and issues no read.
- R8: The memory port is read one location per one-cycle `mem_rd` pulse, and the data is taken one cycle later. No further read is issued while a character of the previous value is still waiting on the transmit stream. The address increments by one per location and wraps at 2^ADDR_W.
- R9: `rx_ready` is low from the cycle after a terminator is accepted until the final line feed of the reply has been accepted, so every byte offered meanwhile is kept. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Engine accepts the received byte |
| tx_data | output | 8 | Reply character |
| tx_valid | output | 1 | Reply character is present |
| tx_ready | input | 1 | Downstream takes the reply character |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_rd` |
| reg_rd | output | 1 | Register read strobe |
| reg_idx | output | $clog2(NUM_REGS) | Register index |
| reg_rdata | input | REG_W | Register read data, valid the cycle after `reg_rd` |

## Verification
The critical coincidence is a new host byte being offered in the same cycle that the last character of a reply goes out. The receive side must stay closed until that final line feed is taken and must then accept the waiting byte without losing it. To provoke this, the bench sends several commands back to back, holding `rx_valid` high on the next command while the current reply is still streaming. It also toggles `tx_ready` at random so the last handshake lands on varying cycles. A scoreboard judges the outcome by comparing every transmitted character, in order, against replies predicted from the command text. At each character handoff the bench also checks that `rx_ready` is low.

// File: rtl/dbg_mon_pkg.sv
package dbg_mon_pkg;

  typedef enum logic [1:0] {
    CMD_MEM  = 2'd0,
    CMD_REGS = 2'd1,
    CMD_ERR  = 2'd2
  } cmd_kind_e;

  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_COMMA = 8'h2C;
  localparam logic [7:0] CH_ERR   = 8'h45;
  localparam logic [7:0] CH_MEMC  = 8'h6D;
  localparam logic [7:0] CH_REGC  = 8'h67;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic is_hex_char(input logic [7:0] c);
    return ((c >= 8'h30) && (c <= 8'h39)) ||
           ((c >= 8'h41) && (c <= 8'h46)) ||
           ((c >= 8'h61) && (c <= 8'h66));
  endfunction

  function automatic logic [3:0] hex_value(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39)      t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else                 t = c - 8'h57;
    return t[3:0];
  endfunction

  function automatic logic is_term(input logic [7:0] c);
    return (c == CH_LF) || (c == CH_CR);
  endfunction

endpackage

// File: rtl/dbg_cmd_parser.sv
module dbg_cmd_parser
  import dbg_mon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              reply_busy,
  output logic              cmd_valid,
  output cmd_kind_e         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_take
);

  typedef enum logic [2:0] {
    PS_IDLE, PS_ADDR, PS_LEN, PS_REGS, PS_DISCARD, PS_HOLD
  } pstate_e;

  pstate_e           st_q, st_d;
  cmd_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              dig_q, dig_d;
  logic              rx_fire;
  logic [3:0]        hv;

  assign rx_ready = (st_q != PS_HOLD) && !reply_busy;
  assign rx_fire  = rx_valid && rx_ready;
  assign hv       = hex_value(rx_data);

  assign cmd_valid = (st_q == PS_HOLD);
  assign cmd_kind  = kind_q;
  assign cmd_addr  = addr_q;
  assign cmd_len   = len_q;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    addr_d = addr_q;
    len_d  = len_q;
    dig_d  = dig_q;
    if (st_q == PS_HOLD) begin
      if (cmd_take) st_d = PS_IDLE;
    end else if (rx_fire) begin
      case (st_q)
        PS_IDLE: begin
          if (rx_data == CH_MEMC) begin
            st_d   = PS_ADDR;
            addr_d = '0;
            len_d  = '0;
            dig_d  = 1'b0;
          end else if (rx_data == CH_REGC) begin
            st_d = PS_REGS;
          end else if (!is_term(rx_data) && (rx_data != CH_SPACE)) begin
            st_d = PS_DISCARD;
          end
        end
        PS_ADDR: begin
          if (is_hex_char(rx_data)) begin
            addr_d = {addr_q[ADDR_W-5:0], hv};
            dig_d  = 1'b1;
          end else if ((rx_data == CH_COMMA) && dig_q) begin
            st_d  = PS_LEN;
            dig_d = 1'b0;
          end else if (is_term(rx_data)) begin
            st_d   = PS_HOLD;
            kind_d = CMD_ERR;
          end else if (!((rx_data == CH_SPACE) && !dig_q)) begin
            st_d = PS_DISCARD;
          end
        end
        PS_LEN: begin
          if (is_hex_char(rx_data)) begin
            len_d = {len_q[LEN_W-5:0], hv};
            dig_d = 1'b1;
          end else if (is_term(rx_data)) begin
            st_d   = PS_HOLD;
            kind_d = dig_q ? CMD_MEM : CMD_ERR;
          end else begin
            st_d = PS_DISCARD;
          end
        end
        PS_REGS: begin
          if (is_term(rx_data)) begin
            st_d   = PS_HOLD;
            kind_d = CMD_REGS;
          end else if (rx_data != CH_SPACE) begin
            st_d = PS_DISCARD;
          end
        end
        PS_DISCARD: begin
          if (is_term(rx_data)) begin
            st_d   = PS_HOLD;
            kind_d = CMD_ERR;
          end
        end
        default: st_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      kind_q <= CMD_ERR;
      addr_q <= '0;
      len_q  <= '0;
      dig_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      len_q  <= len_d;
      dig_q  <= dig_d;
    end
  end

  AST_HOLD_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rx_ready); // R9

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_take) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len))); // R9

endmodule

// File: rtl/dbg_reply_seq.sv
module dbg_reply_seq
  import dbg_mon_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 16,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  cmd_kind_e         cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_take,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              reg_rd,
  output logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] reg_idx,
  input  logic [REG_W-1:0]  reg_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready
);

  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int SH_W    = (DATA_W > REG_W) ? DATA_W : REG_W;
  localparam int NIB_W   = $clog2(SH_W / 4 + 1);
  localparam int MEM_NIB = DATA_W / 4;
  localparam int REG_NIB = REG_W / 4;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ISSUE, RS_CAPT, RS_SEND, RS_ERR, RS_END
  } rstate_e;

  rstate_e           st_q, st_d;
  logic              isreg_q, isreg_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic [NIB_W-1:0]  nib_q, nib_d;

  assign busy     = (st_q != RS_IDLE);
  assign cmd_take = cmd_valid && (st_q == RS_IDLE);
  assign mem_addr = ptr_q;
  assign reg_idx  = ptr_q[IDX_W-1:0];

  always_comb begin
    st_d     = st_q;
    isreg_d  = isreg_q;
    ptr_d    = ptr_q;
    left_d   = left_q;
    sh_d     = sh_q;
    nib_d    = nib_q;
    mem_rd   = 1'b0;
    reg_rd   = 1'b0;
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    case (st_q)
      RS_IDLE: begin
        if (cmd_take) begin
          case (cmd_kind)
            CMD_MEM: begin
              isreg_d = 1'b0;
              ptr_d   = cmd_addr;
              left_d  = cmd_len;
              st_d    = (cmd_len == '0) ? RS_END : RS_ISSUE;
            end
            CMD_REGS: begin
              isreg_d = 1'b1;
              ptr_d   = '0;
              left_d  = LEN_W'(NUM_REGS);
              st_d    = RS_ISSUE;
            end
            default: st_d = RS_ERR;
          endcase
        end
      end
      RS_ISSUE: begin
        mem_rd = !isreg_q;
        reg_rd = isreg_q;
        st_d   = RS_CAPT;
      end
      RS_CAPT: begin
        if (isreg_q) begin
          sh_d  = SH_W'(reg_rdata) << (SH_W - REG_W);
          nib_d = NIB_W'(REG_NIB);
        end else begin
          sh_d  = SH_W'(mem_rdata) << (SH_W - DATA_W);
          nib_d = NIB_W'(MEM_NIB);
        end
        st_d = RS_SEND;
      end
      RS_SEND: begin
        tx_valid = 1'b1;
        tx_data  = nib_to_ascii(sh_q[SH_W-1 -: 4]);
        if (tx_ready) begin
          sh_d  = sh_q << 4;
          nib_d = nib_q - 1'b1;
          if (nib_q == NIB_W'(1)) begin
            left_d = left_q - 1'b1;
            ptr_d  = ptr_q + 1'b1;
            st_d   = (left_q == LEN_W'(1)) ? RS_END : RS_ISSUE;
          end
        end
      end
      RS_ERR: begin
        tx_valid = 1'b1;
        tx_data  = CH_ERR;
        if (tx_ready) st_d = RS_END;
      end
      RS_END: begin
        tx_valid = 1'b1;
        tx_data  = CH_LF;
        if (tx_ready) st_d = RS_IDLE;
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_IDLE;
      isreg_q <= 1'b0;
      ptr_q   <= '0;
      left_q  <= '0;
      sh_q    <= '0;
      nib_q   <= '0;
    end else begin
      st_q    <= st_d;
      isreg_q <= isreg_d;
      ptr_q   <= ptr_d;
      left_q  <= left_d;
      sh_q    <= sh_d;
      nib_q   <= nib_d;
    end
  end

  AST_TX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9

  AST_READ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || reg_rd) |=> (!mem_rd && !reg_rd && !tx_valid)); // R8

  AST_NO_READ_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (!mem_rd && !reg_rd)); // R8

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && reg_rd)); // R8

  AST_TX_CHARSET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (((tx_data >= 8'h30) && (tx_data <= 8'h39)) ||
                  ((tx_data >= 8'h41) && (tx_data <= 8'h46)) ||
                  (tx_data == CH_LF))); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (32'(reg_idx) < NUM_REGS)); // R5

endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_mon_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 16,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 32,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              reg_rd,
  output logic [((NUM_REGS > 1) ? $clog2(NUM_REGS) : 1)-1:0] reg_idx,
  input  logic [REG_W-1:0]  reg_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              cmd_valid;
  cmd_kind_e         cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic              cmd_take;
  logic              reply_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  dbg_cmd_parser #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_parser (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .reply_busy (reply_busy),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .cmd_take   (cmd_take)
  );

  dbg_reply_seq #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .DATA_W   (DATA_W),
    .REG_W    (REG_W),
    .NUM_REGS (NUM_REGS)
  ) u_reply (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_take  (cmd_take),
    .busy      (reply_busy),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .reg_rd    (reg_rd),
    .reg_idx   (reg_idx),
    .reg_rdata (reg_rdata),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready)
  );

  AST_BUSY_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n_i)
    tx_valid |-> !rx_ready); // R9

endmodule

// File: tb/dbg_cmd_engine_tb.sv
module dbg_cmd_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        reg_rd;
  logic [2:0]  reg_idx;
  logic [31:0] reg_rdata = 32'h0;

  int errors = 0;
  int checks = 0;
  int rd_count = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  byte   exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  dbg_cmd_engine u_dut (
    .clk (clk), .rst_n (rst_n),
    .rx_data (rx_data), .rx_valid (rx_valid), .rx_ready (rx_ready),
    .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready),
    .mem_rd (mem_rd), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
    .reg_rd (reg_rd), .reg_idx (reg_idx), .reg_rdata (reg_rdata)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] regf(input int i);
    return 32'hC0DE_0000 + (i * 32'h0001_2345);
  endfunction

  function automatic byte hexch(input logic [3:0] n);
    return (n < 10) ? byte'(8'h30 + n) : byte'(8'h37 + n);
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= memf(mem_addr);
    if (reg_rd) reg_rdata <= regf(int'(reg_idx));
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 tx_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pops one expected character per transmit handshake
  always @(negedge clk) begin
    if (rst_n && mem_rd) rd_count++;
    if (rst_n && tx_valid && tx_ready) begin
      check(rx_ready == 1'b0, "R9", "rx_ready during reply", 32'(rx_ready), 32'h0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected tx byte", 32'(tx_data), 32'h0);
      end else begin
        byte   e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tx_data == e, t, "tx char", 32'(tx_data), 32'(e));
      end
    end
  end

  task automatic push(input byte c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic exp_hex(input logic [31:0] v, input int nibs, input string t);
    for (int i = nibs - 1; i >= 0; i--) push(hexch(v[i*4 +: 4]), t);
  endtask

  task automatic exp_mem(input logic [15:0] a, input int len, input string t);
    for (int k = 0; k < len; k++) exp_hex(32'(memf(a + 16'(k))), 2, t);
    push(8'h0A, t);
  endtask

  task automatic exp_regs(input string t);
    for (int i = 0; i < 8; i++) exp_hex(regf(i), 8, t);
    push(8'h0A, t);
  endtask

  task automatic exp_err(input string t);
    push(8'h45, t);
    push(8'h0A, t);
  endtask

  // Driver: called just after a rising edge
  task automatic send_byte(input byte c);
    rx_data  = c;
    rx_valid = 1'b1;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic wait_drain(input string t);
    int n = 0;
    while ((exp_q.size() != 0) && (n < 5000)) begin
      @(posedge clk);
      n++;
    end
    repeat (6) @(posedge clk);
    #1;
    check(exp_q.size() == 0, t, "reply complete", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: idle outputs after reset
    check(rx_ready == 1'b1, "R1", "rx_ready", 32'(rx_ready), 32'h1);
    check(tx_valid == 1'b0, "R1", "tx_valid", 32'(tx_valid), 32'h0);
    check(mem_rd == 1'b0,   "R1", "mem_rd",   32'(mem_rd),   32'h0);
    check(reg_rd == 1'b0,   "R1", "reg_rd",   32'(reg_rd),   32'h0);
    @(posedge clk); #1;

    // R2 / R8: sixteen locations, one read per location
    rd_count = 0;
    exp_mem(16'h1234, 16, "R2");
    send_str("m 1234,10\r");
    wait_drain("R2");
    check(rd_count == 16, "R8", "read pulses", 32'(rd_count), 32'd16);

    // R2 / R4: no space, mixed case digits, several spaces
    exp_mem(16'h00FF, 3, "R2");
    send_str("m00ff,3\n");
    wait_drain("R2");
    exp_mem(16'h0ABC, 2, "R4");
    send_str("  m   0aBc,2\n");
    wait_drain("R4");

    // R5: register dump, with trailing spaces after g
    exp_regs("R5");
    send_str("g\n");
    wait_drain("R5");
    exp_regs("R4");
    send_str("g  \r");
    wait_drain("R4");

    // R7: zero length gives only a line feed and no read
    rd_count = 0;
    push(8'h0A, "R7");
    send_str("m 10,0\n");
    wait_drain("R7");
    check(rd_count == 0, "R7", "read pulses", 32'(rd_count), 32'd0);

    // R3: empty line and CR LF pair give no extra reply
    exp_regs("R3");
    send_str("\n");
    send_str("g\r\n");
    wait_drain("R3");

    // R6: malformed lines
    exp_err("R6");
    send_str("x\n");
    wait_drain("R6");
    exp_err("R6");
    send_str("m 12q4,2\n");
    wait_drain("R6");
    exp_err("R6");
    send_str("m 1234\n");
    wait_drain("R6");
    exp_err("R6");
    send_str("m ,5\n");
    wait_drain("R6");
    exp_err("R6");
    send_str("m 5,\r");
    wait_drain("R6");
    exp_err("R6");
    send_str("M 1,1\n");
    wait_drain("R6");

    // R8: address wraps past the top
    exp_mem(16'hFFFF, 2, "R8");
    send_str("m ffff,2\n");
    wait_drain("R8");

    // R9: back to back commands with stalling transmit side
    rand_ready = 1'b1;
    exp_mem(16'h0005, 2, "R9");
    exp_regs("R9");
    exp_err("R9");
    exp_mem(16'h7FFE, 4, "R9");
    send_str("m 5,2\ng\nzz\rm7ffe,4\n");
    wait_drain("R9");
    rand_ready = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule